// File: doc/BRIEF.md
# Buffered PWM Compare Output Channel

This block is a single compare channel that turns the count of a shared up/down timer into a PWM waveform on one pin. Software writes a new duty value into a write buffer. The value that is actually compared, called the active value, is loaded from that buffer only at a chosen timer event: the bottom of the count (zero) or the top of the count (the period value). Every channel that chooses the same event therefore changes its duty cycle on the same clock, and no channel shows a glitch part-way through a PWM period. Reads always return the active value.

The channel has two waveform styles. In level style, a match while the timer counts up drives the output to one level, and a match while it counts down drives it to the other. The duty cycle then scales directly with the compare value, and a polarity bit selects which level is which. In toggle style, each match flips the output. With the pair bit set, a match reported by the neighbouring channel also flips it, so two compare values mark the two edges of one pulse. When compare is off, the output level register can be written and becomes the static level of the pin. An output-enable input hands the pin to a static safe level. A sticky flag records compare matches.

Top module: `pwm_cmp_chan`

## Requirements
- R1: After reset the active value is 0, the buffer is 0, the output level is 0 and the match flag is 0.
- R2: `match_o` is 1 exactly when `run_i` and `cmp_en_i` are both 1 and `cnt_i` equals the active value.
- R3: A write is direct when `buf_dis_i`=1 or `run_i`=0. A direct write loads both the buffer and the active value, and `rd_data_o` shows the new value on the next cycle.
- R4: Otherwise a write loads only the buffer, and `rd_data_o` holds its value. The buffer moves to the active value on a cycle with `run_i`=1 where `cnt_i`=0 (when `xfer_sel_i`=0) or `cnt_i`=`prd_i` (when `xfer_sel_i`=1). A buffered write in that same cycle waits for the next such event.
- R5: Level style (`toggle_mode_i`=0) with `reverse_i`=1: an up-count match sets the output to 0 and a down-count match sets it to 1. A match at count 0 counts as up, and a match at count `prd_i` counts as down. With `reverse_i`=0 both levels are inverted.
- R6: In level style, an active value of 0 gives a constant output: 0 when `reverse_i`=1. An active value at or above `prd_i` gives the opposite constant level, because a down-type event is applied whenever the count reaches `prd_i`.
- R7: In toggle style with compare enabled, the output flips on its own match. With `reverse_i`=1 it also flips on `peer_match_i`. Two events in one cycle give a single flip.
- R8: With `cmp_en_i`=0 the output level holds, and a pulse on `lvl_wr_i` loads `lvl_wdata_i` into it. With `cmp_en_i`=1, `lvl_wr_i` has no effect on `lvl_o`.
- R9: `pin_o` equals `lvl_o` when `out_en_i`=1 and equals `safe_lvl_i` when `out_en_i`=0.
- R10: `flag_o` is set on the cycle after a match. It is cleared on the cycle after a `flag_clr_i` pulse. If both happen in the same cycle, the set wins.
- R11: `lvl_o` always shows the current output level, before the output-enable mux.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_i | input | W | Shared timer count |
| prd_i | input | W | Timer period (top count) |
| dir_down_i | input | 1 | 1 while the timer counts down |
| run_i | input | 1 | 1 while the timer is running |
| cmp_en_i | input | 1 | Compare operation enable |
| buf_dis_i | input | 1 | 1 makes every write direct |
| xfer_sel_i | input | 1 | Transfer event: 0 = zero, 1 = period |
| toggle_mode_i | input | 1 | 0 = level style, 1 = toggle style |
| reverse_i | input | 1 | Level style: polarity; toggle style: pair enable |
| wr_en_i | input | 1 | Compare value write strobe |
| wr_data_i | input | W | Compare value to write |
| rd_data_o | output | W | Active compare value |
| lvl_wr_i | input | 1 | Output level write strobe |
| lvl_wdata_i | input | 1 | Output level to write |
| lvl_o | output | 1 | Current output level |
| out_en_i | input | 1 | 1 = waveform on pin, 0 = safe level |
| safe_lvl_i | input | 1 | Static safe pin level |
| pin_o | output | 1 | Pin drive |
| peer_match_i | input | 1 | Match pulse of the paired channel |
| match_o | output | 1 | Compare match pulse of this channel |
| flag_clr_i | input | 1 | Clears the match flag |
| flag_o | output | 1 | Sticky match flag |

## Verification
The following properties are checked on every clock cycle:
- the match condition;
- the flag setting and clearing;
- the stability of the active value between transfer events;
- the level style's up/down responses and the toggle flips;
- the held level while compare is off;
- the safe-level mux.

Two behaviours are visible only across whole timer periods, so only the bench's scenarios can show them. First, duty values of 0 and at or above the period must give a flat waveform with no runt pulse. Second, a buffered value must land exactly at the chosen event while the timer counts up and down.

// File: rtl/pwm_cmp_pkg.sv
// Package: types shared by the compare channel modules.
// Assumes: nothing beyond the standard language.
package pwm_cmp_pkg;

    // Waveform style selected by toggle_mode_i.
    typedef enum logic {
        WAVE_LEVEL  = 1'b0,
        WAVE_TOGGLE = 1'b1
    } wave_style_e;

    // Level-style event produced by the detector.
    typedef struct packed {
        logic up_hit;
        logic down_hit;
    } lvl_evt_t;

endpackage

// File: rtl/pwm_cmp_store.sv
// Module: holds the write buffer and the active compare value.
// A write is direct when buffering is off or the timer is stopped.
// Otherwise the buffer moves to the active value on xfer_i.
// Assumes: xfer_i is already qualified by the running timer.
module pwm_cmp_store #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         direct_i,
    input  logic         xfer_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] active_o
);

    logic [W-1:0] shadow_q;
    logic [W-1:0] active_q;

    // Update the buffer and the active value from writes and transfer events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (xfer_i && !direct_i) begin
                active_q <= shadow_q;
            end
            if (wr_en_i) begin
                shadow_q <= wr_data_i;
                if (direct_i) begin
                    active_q <= wr_data_i;
                end
            end
        end
    end

    assign active_o = active_q;

endmodule

// File: rtl/pwm_cmp_detect.sv
// Module: compares the count with the active value.
// Produces:
// - the match pulse;
// - the buffer transfer event;
// - the level-style up/down events.
// A match at count 0 is treated as up-counting and a match at the period as
// down-counting.
// A count at the period with an active value at or above it also gives a
// down event, so large duty values stay flat.
// Assumes: prd_i is the top of the up/down count.
module pwm_cmp_detect
    import pwm_cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         run_i,
    input  logic         cmp_en_i,
    input  logic         xfer_sel_i,
    input  logic         dir_down_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] prd_i,
    input  logic [W-1:0] active_i,
    output logic         match_o,
    output logic         xfer_o,
    output lvl_evt_t     evt_o
);

    logic at_zero;
    logic at_top;
    logic top_hold;

    // Decode count positions and the saturation case.
    always_comb begin
        at_zero  = (cnt_i == '0);
        at_top   = (cnt_i == prd_i);
        top_hold = run_i && cmp_en_i && at_top && (active_i >= prd_i);
    end

    // Match pulse and transfer event.
    always_comb begin
        match_o = run_i && cmp_en_i && (cnt_i == active_i);
        xfer_o  = run_i && (xfer_sel_i ? at_top : at_zero);
    end

    // Level-style event by effective count direction.
    always_comb begin
        evt_o.down_hit = top_hold || (match_o && dir_down_i && !at_zero);
        evt_o.up_hit   = match_o && !top_hold && !evt_o.down_hit;
    end

endmodule

// File: rtl/pwm_cmp_wave.sv
// Module: output level register and pin mux.
// Compare off: the level holds and can be written.
// Level style: events drive fixed levels, chosen by the polarity bit.
// Toggle style: matches (own, plus peer when paired) flip the level.
// Assumes: the events come from pwm_cmp_detect in the same cycle.
module pwm_cmp_wave
    import pwm_cmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmp_en_i,
    input  logic     toggle_mode_i,
    input  logic     reverse_i,
    input  logic     match_i,
    input  logic     peer_match_i,
    input  lvl_evt_t evt_i,
    input  logic     lvl_wr_i,
    input  logic     lvl_wdata_i,
    input  logic     out_en_i,
    input  logic     safe_lvl_i,
    output logic     lvl_o,
    output logic     pin_o
);

    wave_style_e style;
    logic        level_q;

    assign style = wave_style_e'(toggle_mode_i);

    // Advance the output level for the selected style.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else if (!cmp_en_i) begin
            if (lvl_wr_i) begin
                level_q <= lvl_wdata_i;
            end
        end else if (style == WAVE_TOGGLE) begin
            if (match_i || (reverse_i && peer_match_i)) begin
                level_q <= !level_q;
            end
        end else begin
            if (evt_i.down_hit) begin
                level_q <= reverse_i;
            end else if (evt_i.up_hit) begin
                level_q <= !reverse_i;
            end
        end
    end

    // Hand the pin to the safe level when the output is disabled.
    always_comb begin
        lvl_o = level_q;
        pin_o = out_en_i ? level_q : safe_lvl_i;
    end

endmodule

// File: rtl/pwm_cmp_chan.sv
// Module: top of the buffered PWM compare channel.
// It ties together the value store, the match detector, the waveform stage
// and the sticky match flag.
// Assumes: the count, the direction and run come from one shared timer.
module pwm_cmp_chan
    import pwm_cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] prd_i,
    input  logic         dir_down_i,
    input  logic         run_i,
    input  logic         cmp_en_i,
    input  logic         buf_dis_i,
    input  logic         xfer_sel_i,
    input  logic         toggle_mode_i,
    input  logic         reverse_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] rd_data_o,
    input  logic         lvl_wr_i,
    input  logic         lvl_wdata_i,
    output logic         lvl_o,
    input  logic         out_en_i,
    input  logic         safe_lvl_i,
    output logic         pin_o,
    input  logic         peer_match_i,
    output logic         match_o,
    input  logic         flag_clr_i,
    output logic         flag_o
);

    logic [W-1:0] active;
    logic         direct;
    logic         xfer;
    logic         hit;
    lvl_evt_t     evt;
    logic         flag_q;

    assign direct = buf_dis_i || !run_i;

    pwm_cmp_store #(.W(W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .direct_i  (direct),
        .xfer_i    (xfer),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .active_o  (active)
    );

    pwm_cmp_detect #(.W(W)) detect_i (
        .run_i      (run_i),
        .cmp_en_i   (cmp_en_i),
        .xfer_sel_i (xfer_sel_i),
        .dir_down_i (dir_down_i),
        .cnt_i      (cnt_i),
        .prd_i      (prd_i),
        .active_i   (active),
        .match_o    (hit),
        .xfer_o     (xfer),
        .evt_o      (evt)
    );

    pwm_cmp_wave wave_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmp_en_i      (cmp_en_i),
        .toggle_mode_i (toggle_mode_i),
        .reverse_i     (reverse_i),
        .match_i       (hit),
        .peer_match_i  (peer_match_i),
        .evt_i         (evt),
        .lvl_wr_i      (lvl_wr_i),
        .lvl_wdata_i   (lvl_wdata_i),
        .out_en_i      (out_en_i),
        .safe_lvl_i    (safe_lvl_i),
        .lvl_o         (lvl_o),
        .pin_o         (pin_o)
    );

    // Sticky match flag; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (flag_clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign rd_data_o = active;
    assign match_o   = hit;
    assign flag_o    = flag_q;

endmodule

// File: rtl/pwm_cmp_chan_chk.sv
// Checker: cycle properties of pwm_cmp_chan, bound to every instance.
module pwm_cmp_chan_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cnt_i,
    input logic [W-1:0] prd_i,
    input logic         dir_down_i,
    input logic         run_i,
    input logic         cmp_en_i,
    input logic         buf_dis_i,
    input logic         xfer_sel_i,
    input logic         toggle_mode_i,
    input logic         reverse_i,
    input logic         wr_en_i,
    input logic [W-1:0] wr_data_i,
    input logic [W-1:0] rd_data_o,
    input logic         lvl_wr_i,
    input logic         lvl_wdata_i,
    input logic         lvl_o,
    input logic         out_en_i,
    input logic         safe_lvl_i,
    input logic         pin_o,
    input logic         peer_match_i,
    input logic         match_o,
    input logic         flag_clr_i,
    input logic         flag_o
);

    logic xfer_evt;
    assign xfer_evt = run_i && (xfer_sel_i ? (cnt_i == prd_i) : (cnt_i == '0));

    // R2
    match_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (run_i && cmp_en_i && (cnt_i == rd_data_o)));

    // R4
    buffered_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !buf_dis_i && !xfer_evt) |=> $stable(rd_data_o));

    // R3
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (buf_dis_i || !run_i)) |=> (rd_data_o == $past(wr_data_i)));

    // R5
    level_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && !toggle_mode_i && reverse_i && dir_down_i && (cnt_i != '0)) |=> lvl_o);

    // R7
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en_i && toggle_mode_i && (match_o || (reverse_i && peer_match_i)))
            |=> (lvl_o != $past(lvl_o)));

    // R8
    level_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en_i && lvl_wr_i) |=> (lvl_o == $past(lvl_wdata_i)));

    // R8
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en_i && !lvl_wr_i) |=> $stable(lvl_o));

    // R9
    safe_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_i |-> (pin_o == safe_lvl_i));

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> flag_o);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !match_o) |=> !flag_o);

endmodule

bind pwm_cmp_chan pwm_cmp_chan_chk #(.W(W)) chk_i (.*);

// File: tb/pwm_cmp_chan_tb_top.sv
`timescale 1ns/1ps
module pwm_cmp_chan_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_i = '0;
    logic [W-1:0] prd_i = 16'd20;
    logic         dir_down_i = 1'b0;
    logic         run_i = 1'b0;
    logic         cmp_en_i = 1'b0;
    logic         buf_dis_i = 1'b0;
    logic         xfer_sel_i = 1'b0;
    logic         toggle_mode_i = 1'b0;
    logic         reverse_i = 1'b0;
    logic         wr_en_i = 1'b0;
    logic [W-1:0] wr_data_i = '0;
    logic [W-1:0] rd_data_o;
    logic         lvl_wr_i = 1'b0;
    logic         lvl_wdata_i = 1'b0;
    logic         lvl_o;
    logic         out_en_i = 1'b0;
    logic         safe_lvl_i = 1'b0;
    logic         pin_o;
    logic         peer_match_i = 1'b0;
    logic         match_o;
    logic         flag_clr_i = 1'b0;
    logic         flag_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Model state
    logic [W-1:0] m_act = '0;
    logic [W-1:0] m_buf = '0;
    logic         m_lvl = 1'b0;
    logic         m_flag = 1'b0;

    always #4 clk = ~clk;

    pwm_cmp_chan #(.W(W)) dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_match(input logic [W-1:0] act);
        return run_i && cmp_en_i && (cnt_i == act);
    endfunction

    // Check outputs against the model, advance the model, then move the timer.
    task automatic step();
        logic mm, xf, top_hold, dn, up;
        #1;
        mm = exp_match(m_act);
        check("R2 match", match_o, mm);
        check(buf_dis_i ? "R3 read" : "R4 read", rd_data_o, m_act);
        check(!cmp_en_i ? "R8 level" : (toggle_mode_i ? "R7 level" : "R5 level"), lvl_o, m_lvl);
        check("R9 pin", pin_o, out_en_i ? m_lvl : safe_lvl_i);
        check("R10 flag", flag_o, m_flag);
        xf = run_i && (xfer_sel_i ? (cnt_i == prd_i) : (cnt_i == '0));
        top_hold = run_i && cmp_en_i && (cnt_i == prd_i) && (m_act >= prd_i);
        dn = top_hold || (mm && dir_down_i && (cnt_i != '0));
        up = mm && !dn;
        if (!cmp_en_i) begin
            if (lvl_wr_i) m_lvl = lvl_wdata_i;
        end else if (toggle_mode_i) begin
            if (mm || (reverse_i && peer_match_i)) m_lvl = !m_lvl;
        end else if (dn) begin
            m_lvl = reverse_i;
        end else if (up) begin
            m_lvl = !reverse_i;
        end
        if (mm) m_flag = 1'b1;
        else if (flag_clr_i) m_flag = 1'b0;
        if (xf && !(buf_dis_i || !run_i)) m_act = m_buf;
        if (wr_en_i) begin
            m_buf = wr_data_i;
            if (buf_dis_i || !run_i) m_act = wr_data_i;
        end
        @(negedge clk);
        if (run_i) begin
            if (!dir_down_i) begin
                if (cnt_i >= prd_i) begin dir_down_i = 1'b1; cnt_i = cnt_i - 1'b1; end
                else cnt_i = cnt_i + 1'b1;
            end else begin
                if (cnt_i == '0) begin dir_down_i = 1'b0; cnt_i = cnt_i + 1'b1; end
                else cnt_i = cnt_i - 1'b1;
            end
        end
    endtask

    task automatic clear_strobes();
        wr_en_i = 1'b0;
        lvl_wr_i = 1'b0;
        flag_clr_i = 1'b0;
        peer_match_i = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check("R1 active", rd_data_o, 0);
        check("R1 level", lvl_o, 0);
        check("R11 level", lvl_o, 0);
        check("R1 flag", flag_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: the level write is ignored while compare is enabled.
        cmp_en_i = 1'b1; run_i = 1'b0; lvl_wr_i = 1'b1; lvl_wdata_i = 1'b1;
        step();
        clear_strobes();
        step();
        check("R8 ignored write", lvl_o, 0);

        // R3: direct write while the timer is stopped.
        cmp_en_i = 1'b0; wr_en_i = 1'b1; wr_data_i = 16'd7;
        step();
        clear_strobes();
        step();
        check("R3 stopped write", rd_data_o, 7);

        // R4: a buffered write holds until the period event.
        run_i = 1'b1; cmp_en_i = 1'b1; xfer_sel_i = 1'b1; cnt_i = 16'd2; dir_down_i = 1'b0;
        wr_en_i = 1'b1; wr_data_i = 16'd11;
        step();
        clear_strobes();
        while (cnt_i != prd_i) begin
            check("R4 held", rd_data_o, 7);
            step();
        end
        step();
        check("R4 after period event", rd_data_o, 11);

        // R6: flat waveforms for 0 and for values at or above the period.
        toggle_mode_i = 1'b0; reverse_i = 1'b1; buf_dis_i = 1'b1; out_en_i = 1'b1;
        for (int v = 0; v < 3; v++) begin
            wr_en_i = 1'b1;
            wr_data_i = (v == 0) ? 16'd0 : (v == 1) ? prd_i : prd_i + 16'd5;
            step();
            clear_strobes();
            repeat (2 * 20 + 3) step();
            for (int k = 0; k < 2 * 20; k++) begin
                check("R6 flat level", lvl_o, (v == 0) ? 0 : 1);
                step();
            end
        end

        // R9: safe level replaces the waveform.
        out_en_i = 1'b0; safe_lvl_i = 1'b1;
        step();
        check("R9 safe pin", pin_o, 1);

        // Random segments checked against the model.
        for (int seg = 0; seg < 40; seg++) begin
            prd_i = 16'($urandom_range(4, 40));
            cnt_i = 16'($urandom_range(0, 3));
            dir_down_i = 1'b0;
            cmp_en_i = ($urandom_range(0, 4) != 0);
            buf_dis_i = $urandom_range(0, 1);
            xfer_sel_i = $urandom_range(0, 1);
            toggle_mode_i = $urandom_range(0, 1);
            reverse_i = $urandom_range(0, 1);
            out_en_i = $urandom_range(0, 1);
            safe_lvl_i = $urandom_range(0, 1);
            for (int c = 0; c < 300; c++) begin
                run_i = ($urandom_range(0, 15) != 0);
                wr_en_i = ($urandom_range(0, 19) == 0);
                wr_data_i = 16'($urandom_range(0, 45));
                lvl_wr_i = ($urandom_range(0, 9) == 0);
                lvl_wdata_i = $urandom_range(0, 1);
                flag_clr_i = ($urandom_range(0, 7) == 0);
                peer_match_i = ($urandom_range(0, 11) == 0);
                if ($urandom_range(0, 50) == 0) cmp_en_i = !cmp_en_i;
                step();
            end
            clear_strobes();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule